// File: doc/BRIEF.md
# GPIO Pin Interrupt Sense Logic

This block does the input side of a general-purpose pin port. It takes the external pin levels and five per-pin control vectors. From them it keeps the captured input bits of the port's data word and a per-pin interrupt-state vector. The register bank that owns the control vectors reads both outputs. That bank gates the interrupt state with its masks to form request lines. Register decoding and mask gating are not part of this block.

Every pin level first passes through a two-flop synchronizer. A pin is sampled only when it is configured as an input and its receive enable is set. On a sampled cycle, the stored data bit takes the synchronized level. In the same clock edge the old stored bit is compared with the new level to decide on an interrupt. The trigger-edge, dual-edge and polarity bits select one of five sense modes: level-high, level-low, rising, falling or any-edge. Level interrupts follow the pin and clear on their own. Edge events are single-cycle pulses.

When a pin goes from unsampled to sampled, the first comparison uses the data bit stored earlier. That bit may be stale, so an edge pin can produce one event at that moment.

Top module: `gpio_irq_sense`

## Requirements
- R1: While `rst_n` is low at a clock edge, every bit of `cap_data_o` and `irq_state_o` is 0.
- R2: A pin with `cfg_is_out_i`=1 or `cfg_rx_en_i`=0 is not sampled, and its `cap_data_o` bit keeps its value whatever the pin does.
- R3: The `irq_state_o` bit of a pin that is not sampled is 0 one clock after that condition is seen.
- R4: A sampled pin's `cap_data_o` bit takes the pin level after three rising clock edges: two synchronizer stages and the capture register. The output does not change earlier.
- R5: Level-high mode (`cfg_edge_i`=0, `cfg_pol_i`=0): the `irq_state_o` bit is 1 while the captured level is 1.
- R6: Level-low mode (`cfg_edge_i`=0, `cfg_pol_i`=1): the `irq_state_o` bit is 1 while the captured level is 0.
- R7: In either level mode, the `irq_state_o` bit returns to 0 as soon as the captured level is back at its inactive value. No clear action is needed.
- R8: Rising mode (`cfg_edge_i`=1, `cfg_dual_i`=0, `cfg_pol_i`=0): an event is raised when the stored data bit is 0 and the new level is 1.
- R9: Falling mode (`cfg_edge_i`=1, `cfg_dual_i`=0, `cfg_pol_i`=1): an event is raised when the stored data bit is 1 and the new level is 0.
- R10: Any-edge mode (`cfg_edge_i`=1, `cfg_dual_i`=1): an event is raised on every change of level, and `cfg_pol_i` has no effect.
- R11: An edge event is an `irq_state_o` pulse of exactly one clock cycle. An edge pin whose level does not change shows 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| pin_level_i | input | N | Asynchronous external pin levels |
| cfg_is_out_i | input | N | 1 = pin is an output and is not sampled |
| cfg_rx_en_i | input | N | 1 = input receiver enabled |
| cfg_edge_i | input | N | 1 = edge sense, 0 = level sense |
| cfg_dual_i | input | N | 1 = both edges (edge sense only) |
| cfg_pol_i | input | N | Level: 1 = active low. Single edge: 1 = falling |
| cap_data_o | output | N | Captured input bits of the data word |
| irq_state_o | output | N | Per-pin interrupt state |

## Verification
The assertions check four things on every cycle for every pin. An unsampled pin holds its data bit and shows no interrupt. A sampled pin captures its synchronizer output. A level-mode interrupt equals the captured level against the polarity. An edge pin with no level change shows nothing, and a rising transition always produces a pulse. Some behaviour is visible only in the bench scenarios, because it ties the pin ports to outputs several cycles later. This covers the exact three-edge latency, the single-cycle width of each edge pulse, and the falling and any-edge cases. These are checked by sweeping pin patterns over every mode, with the mode assignment rotated across all pins.

// File: rtl/gpio_sense_pkg.sv
// Package: shared sense-mode type and the decode from the three control bits.
// Assumes: one trigger-edge, one dual-edge and one polarity bit per pin.
package gpio_sense_pkg;

    typedef enum logic [2:0] {
        MODE_LVL_HIGH = 3'd0,
        MODE_LVL_LOW  = 3'd1,
        MODE_RISE     = 3'd2,
        MODE_FALL     = 3'd3,
        MODE_ANY      = 3'd4
    } sense_mode_e;

    // Map the trigger-edge, dual-edge and polarity bits to one sense mode.
    function automatic sense_mode_e pick_mode(input logic trig_edge,
                                              input logic dual,
                                              input logic pol);
        sense_mode_e m;
        if (!trig_edge) begin
            m = pol ? MODE_LVL_LOW : MODE_LVL_HIGH;
        end else if (dual) begin
            m = MODE_ANY;
        end else begin
            m = pol ? MODE_FALL : MODE_RISE;
        end
        return m;
    endfunction

endpackage

// File: rtl/gpio_sync_stage.sv
// Module: multi-flop synchronizer for a vector of asynchronous pin levels.
// Assumes: each bit is independent (no bus coherency is needed) and STAGES >= 2.
module gpio_sync_stage #(
    parameter int unsigned W      = 16,
    parameter int unsigned STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_i,
    output logic [W-1:0] sync_o
);

    logic [W-1:0] stg [STAGES];

    // First stage captures the raw asynchronous levels.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stg[0] <= '0;
        end else begin
            stg[0] <= async_i;
        end
    end

    for (genvar s = 1; s < STAGES; s++) begin : g_stage
        // Each further stage re-times the previous one.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                stg[s] <= '0;
            end else begin
                stg[s] <= stg[s-1];
            end
        end
    end

    assign sync_o = stg[STAGES-1];

endmodule

// File: rtl/gpio_mode_decode.sv
// Module: turns the per-pin control vectors into one sense mode per pin.
// Assumes: the control vectors are static or change synchronously to clk.
module gpio_mode_decode
    import gpio_sense_pkg::*;
#(
    parameter int unsigned N = 16
) (
    input  logic [N-1:0] trig_edge_i,
    input  logic [N-1:0] dual_i,
    input  logic [N-1:0] pol_i,
    output sense_mode_e  mode_o [N]
);

    for (genvar i = 0; i < N; i++) begin : g_pin
        // Pure combinational decode for pin i.
        always_comb begin
            mode_o[i] = pick_mode(trig_edge_i[i], dual_i[i], pol_i[i]);
        end
    end

endmodule

// File: rtl/gpio_sense_cell.sv
// Module: per-pin capture register and interrupt decision.
// Assumes: lvl_i is already synchronized. When take_i is low the captured bit
// holds and the interrupt state is forced to 0. Edge events last one cycle
// because the captured bit catches up with the level on the same edge.
module gpio_sense_cell
    import gpio_sense_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        take_i,
    input  logic        lvl_i,
    input  sense_mode_e mode_i,
    output logic        data_q_o,
    output logic        irq_q_o
);

    logic hit;

    // Interrupt decision from the stored bit (old) and the new level.
    always_comb begin
        case (mode_i)
            MODE_LVL_HIGH: hit = lvl_i;
            MODE_LVL_LOW:  hit = ~lvl_i;
            MODE_RISE:     hit = ~data_q_o & lvl_i;
            MODE_FALL:     hit = data_q_o & ~lvl_i;
            MODE_ANY:      hit = data_q_o ^ lvl_i;
            default:       hit = 1'b0;
        endcase
    end

    // Capture the level and register the interrupt state when sampled.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data_q_o <= 1'b0;
            irq_q_o  <= 1'b0;
        end else if (!take_i) begin
            irq_q_o  <= 1'b0;
        end else begin
            data_q_o <= lvl_i;
            irq_q_o  <= hit;
        end
    end

endmodule

// File: rtl/gpio_irq_sense.sv
// Module: top of the pin interrupt sense logic. It synchronizes the pins,
// decodes the per-pin sense mode and runs one capture/interrupt cell per pin.
// Assumes: control vectors come from a register bank in the clk domain.
module gpio_irq_sense
    import gpio_sense_pkg::*;
#(
    parameter int unsigned N           = 16,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] pin_level_i,
    input  logic [N-1:0] cfg_is_out_i,
    input  logic [N-1:0] cfg_rx_en_i,
    input  logic [N-1:0] cfg_edge_i,
    input  logic [N-1:0] cfg_dual_i,
    input  logic [N-1:0] cfg_pol_i,
    output logic [N-1:0] cap_data_o,
    output logic [N-1:0] irq_state_o
);

    logic [N-1:0] pin_sync;
    logic [N-1:0] pin_take;
    sense_mode_e  pin_mode [N];

    // A pin is sampled only as an enabled input.
    assign pin_take = ~cfg_is_out_i & cfg_rx_en_i;

    gpio_sync_stage #(.W(N), .STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (pin_level_i),
        .sync_o  (pin_sync)
    );

    gpio_mode_decode #(.N(N)) u_mode (
        .trig_edge_i (cfg_edge_i),
        .dual_i      (cfg_dual_i),
        .pol_i       (cfg_pol_i),
        .mode_o      (pin_mode)
    );

    for (genvar i = 0; i < N; i++) begin : g_cell
        gpio_sense_cell u_cell (
            .clk      (clk),
            .rst_n    (rst_n),
            .take_i   (pin_take[i]),
            .lvl_i    (pin_sync[i]),
            .mode_i   (pin_mode[i]),
            .data_q_o (cap_data_o[i]),
            .irq_q_o  (irq_state_o[i])
        );
    end

endmodule

// File: rtl/gpio_irq_sense_chk.sv
// Module: assertion checker bound to gpio_irq_sense. It checks each pin on
// every cycle. Assumes: sync_lvl is the synchronizer output inside the top.
module gpio_irq_sense_chk #(
    parameter int unsigned N = 16
) (
    input logic         clk,
    input logic         rst_n,
    input logic [N-1:0] cfg_is_out_i,
    input logic [N-1:0] cfg_rx_en_i,
    input logic [N-1:0] cfg_edge_i,
    input logic [N-1:0] cfg_dual_i,
    input logic [N-1:0] cfg_pol_i,
    input logic [N-1:0] sync_lvl,
    input logic [N-1:0] cap_data_o,
    input logic [N-1:0] irq_state_o
);

    // Reset clears both outputs on the next edge.
    assert_reset_clear_R1: assert property (@(posedge clk)
        !rst_n |=> (cap_data_o == '0 && irq_state_o == '0));

    for (genvar i = 0; i < N; i++) begin : g_pin
        // Unsampled pin keeps its data bit.
        assert_gate_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
            (cfg_is_out_i[i] || !cfg_rx_en_i[i]) |=> $stable(cap_data_o[i]));

        // Unsampled pin shows no interrupt.
        assert_off_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
            (cfg_is_out_i[i] || !cfg_rx_en_i[i]) |=> !irq_state_o[i]);

        // Sampled pin captures the synchronizer output.
        assert_capture_R4: assert property (@(posedge clk) disable iff (!rst_n)
            (!cfg_is_out_i[i] && cfg_rx_en_i[i]) |=> cap_data_o[i] == $past(sync_lvl[i]));

        // Level modes: interrupt equals captured level against polarity (R5, R6, R7).
        assert_level_track_R7: assert property (@(posedge clk) disable iff (!rst_n)
            (!cfg_is_out_i[i] && cfg_rx_en_i[i] && !cfg_edge_i[i])
            |=> irq_state_o[i] == (cap_data_o[i] ^ $past(cfg_pol_i[i])));

        // Rising transition always produces an event.
        assert_rise_fire_R8: assert property (@(posedge clk) disable iff (!rst_n)
            (!cfg_is_out_i[i] && cfg_rx_en_i[i] && cfg_edge_i[i] && !cfg_dual_i[i]
             && !cfg_pol_i[i] && !cap_data_o[i] && sync_lvl[i]) |=> irq_state_o[i]);

        // Edge pin with no level change shows no event.
        assert_edge_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
            (!cfg_is_out_i[i] && cfg_rx_en_i[i] && cfg_edge_i[i]
             && (sync_lvl[i] == cap_data_o[i])) |=> !irq_state_o[i]);
    end

endmodule

bind gpio_irq_sense gpio_irq_sense_chk #(.N(N)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .cfg_is_out_i (cfg_is_out_i),
    .cfg_rx_en_i  (cfg_rx_en_i),
    .cfg_edge_i   (cfg_edge_i),
    .cfg_dual_i   (cfg_dual_i),
    .cfg_pol_i    (cfg_pol_i),
    .sync_lvl     (pin_sync),
    .cap_data_o   (cap_data_o),
    .irq_state_o  (irq_state_o)
);

// File: tb/gpio_irq_sense_tb.sv
`timescale 1ns/1ps
module gpio_irq_sense_tb;

    localparam int N = 16;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [N-1:0] pins = '0;
    logic [N-1:0] c_out = '0, c_en = '0, c_edge = '0, c_dual = '0, c_pol = '0;
    logic [N-1:0] cap_data, irq_state;
    logic [N-1:0] m_data = '0;
    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #10 clk = ~clk;

    gpio_irq_sense #(.N(N)) u_dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .pin_level_i  (pins),
        .cfg_is_out_i (c_out),
        .cfg_rx_en_i  (c_en),
        .cfg_edge_i   (c_edge),
        .cfg_dual_i   (c_dual),
        .cfg_pol_i    (c_pol),
        .cap_data_o   (cap_data),
        .irq_state_o  (irq_state)
    );

    task automatic chk(input string tag, input logic [N-1:0] act, input logic [N-1:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Rotate the mode assignment: kind = (pin + round) % 7.
    task automatic configure(input int rnd);
        logic [N-1:0] on, lvl;
        @(negedge clk);
        for (int i = 0; i < N; i++) begin
            int k;
            k = (i + rnd) % 7;
            c_out[i]  = (k == 6);
            c_en[i]   = (k != 5);
            c_edge[i] = (k >= 2 && k <= 4);
            c_dual[i] = (k == 4);
            c_pol[i]  = (k == 1) || (k == 3) || (k == 5) || (k == 6) || (k == 4 && i[0]);
        end
        repeat (4) @(negedge clk);
        on  = ~c_out & c_en;
        m_data = (on & pins) | (~on & m_data);
        lvl = on & ~c_edge & (pins ^ c_pol);
        chk("R2 settle data", cap_data, m_data);
        chk("R7 settle irq", irq_state, lvl);
    endtask

    task automatic apply(input logic [N-1:0] p);
        logic [N-1:0] on, d_exp, lvl_exp, lvl_prev, r_m, f_m, a_m, ev_r, ev_f, ev_a, lh, ll;
        on       = ~c_out & c_en;
        lvl_prev = on & ~c_edge & (m_data ^ c_pol);
        @(negedge clk);
        pins = p;
        d_exp   = (on & p) | (~on & m_data);
        lvl_exp = on & ~c_edge & (p ^ c_pol);
        lh  = on & ~c_edge & ~c_pol;
        ll  = on & ~c_edge & c_pol;
        r_m = on & c_edge & ~c_dual & ~c_pol;
        f_m = on & c_edge & ~c_dual & c_pol;
        a_m = on & c_edge & c_dual;
        ev_r = r_m & ~m_data & p;
        ev_f = f_m & m_data & ~p;
        ev_a = a_m & (m_data ^ p);
        repeat (2) @(negedge clk);
        chk("R4 latency data", cap_data, m_data);
        chk("R4 latency irq", irq_state, lvl_prev);
        @(negedge clk);
        chk("R4 capture", cap_data & on, p & on);
        chk("R2 hold", cap_data & ~on, m_data & ~on);
        chk("R3 off irq", irq_state & ~on, '0);
        chk("R5 level high", irq_state & lh, lvl_exp & lh);
        chk("R6 level low", irq_state & ll, lvl_exp & ll);
        chk("R8 rise", irq_state & r_m, ev_r);
        chk("R9 fall", irq_state & f_m, ev_f);
        chk("R10 any", irq_state & a_m, ev_a);
        @(negedge clk);
        chk("R11 pulse width", irq_state & on & c_edge, '0);
        chk("R7 level track", irq_state & on & ~c_edge, lvl_exp);
        chk("R3 off irq later", irq_state & ~on, '0);
        m_data = d_exp;
    endtask

    initial begin
        logic [N-1:0] pats [10];
        logic [N-1:0] lfsr;
        pats = '{16'hFFFF, 16'h0000, 16'hA5A5, 16'h5A5A, 16'hFFFF,
                 16'h00FF, 16'hFF00, 16'h0F0F, 16'hF0F0, 16'h0000};
        c_en = '1;
        pins = '1;
        repeat (4) @(negedge clk);
        chk("R1 reset data", cap_data, '0);
        chk("R1 reset irq", irq_state, '0);
        @(negedge clk);
        rst_n = 1'b1;
        pins  = '0;
        lfsr  = 16'hACE1;
        for (int r = 0; r < 7; r++) begin
            configure(r);
            for (int k = 0; k < 10; k++) apply(pats[k]);
            for (int k = 0; k < 6; k++) begin
                lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
                apply(lfsr);
            end
        end
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

endmodule